// File: doc/BRIEF.md
# Two's Complement Floating-Point Normaliser

This block brings a floating-point value into normal form. The value is a two's complement fixed-point mantissa with the binary point just after its sign bit, scaled by a two's complement exponent. The default widths are 8 and 4 bits. A mantissa is in normal form when its two top bits differ. A positive mantissa then starts 01 and a negative one starts 10. In that form each value has exactly one encoding and keeps the most significant bits.

A value is offered with `in_valid` while `busy` is low. While the top two mantissa bits are equal, the block shifts the mantissa left by one place per clock, fills with zero, and lowers the exponent by one. When it finishes, `out_valid` pulses high with the result. A zero mantissa has no normal form and is reported at once. If the exponent reaches its most negative value while shifts are still needed, the block stops and flags underflow.

Top module: `tc_float_normaliser`

## Requirements
- R1: While reset is active, and until the internal reset is released, `busy`, `out_valid` and `out_uflow` are 0, and `out_mant` and `out_exp` are zero.
- R2: A non-zero input whose top two mantissa bits differ (01 or 10) is returned unchanged. `out_valid` rises after the accepting edge, and `busy` stays low.
- R3: During each cycle in which `busy` is high, the next edge either performs one step or ends the run. A step shifts the mantissa left by one with a zero fill and lowers the exponent by exactly one.
- R4: A run ends when the shifted mantissa's top two bits differ. If an input needs n shifts, `out_valid` is first high after edge n+1, counting the accepting edge as edge 1. A mantissa of W bits needs at most W-1 shifts (11111111 becomes 10000000).
- R5: An all-zero mantissa finishes after the accepting edge with `out_mant` = 0, `out_exp` = 1000 (the most negative exponent) and `out_uflow` = 0.
- R6: If a shift is still needed while the exponent equals 1000, the block takes no further step. It raises `out_valid` together with `out_uflow` = 1 and presents the partly shifted mantissa with exponent 1000.
- R7: `in_valid` has no effect while `busy` is high.
- R8: `out_valid` is high for one cycle per result. `out_uflow` is cleared when the next input is accepted.
- R9: Mantissa 00010111 with exponent 0101 normalises to 01011100 with exponent 0011, which is 5.75. A negative input 11110100 with exponent 0000 gives 10100000 with exponent 1101.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Offer a value; accepted when `busy` is low |
| in_mant | input | MANT_W | Two's complement mantissa, binary point after the sign bit |
| in_exp | input | EXP_W | Two's complement exponent |
| busy | output | 1 | Normalisation in progress |
| out_valid | output | 1 | One-cycle pulse: result ready |
| out_mant | output | MANT_W | Result mantissa |
| out_exp | output | EXP_W | Result exponent |
| out_uflow | output | 1 | Exponent underflow on the latest result |

## Verification
The assertions assume that `rst_n` is low at the first clock edge, so that no `$past` term ever reads an unreset state. They also assume that every input bit is driven to a known value at each edge, including edges where `in_valid` is low. The bench holds reset from time zero and keeps `in_valid`, `in_mant` and `in_exp` at defined values throughout. It changes inputs only on falling edges. It also deliberately drives `in_valid` during a run, so that the ignore rule is exercised while the assertions on shifting stay live.

// File: rtl/tcfn_pkg.sv
package tcfn_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } tcfn_state_e;
endpackage

// File: rtl/tcfn_rst_sync.sv
module tcfn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tcfn_classify.sv
module tcfn_classify #(
  parameter int MW = 8
) (
  input  logic [MW-1:0] mant,
  output logic          is_zero,
  output logic          is_norm
);
  assign is_zero = (mant == '0);
  assign is_norm = mant[MW-1] ^ mant[MW-2];
endmodule

// File: rtl/tcfn_step.sv
module tcfn_step #(
  parameter int MW = 8,
  parameter int EW = 4
) (
  input  logic [MW-1:0] mant,
  input  logic [EW-1:0] expo,
  output logic [MW-1:0] mant_sh,
  output logic [EW-1:0] expo_dec,
  output logic          sh_norm,
  output logic          at_floor
);
  localparam logic [EW-1:0] EXP_FLOOR = {1'b1, {(EW-1){1'b0}}};
  localparam logic [EW-1:0] EXP_ONE   = {{(EW-1){1'b0}}, 1'b1};

  assign mant_sh  = {mant[MW-2:0], 1'b0};
  assign expo_dec = expo - EXP_ONE;
  assign sh_norm  = mant_sh[MW-1] ^ mant_sh[MW-2];
  assign at_floor = (expo == EXP_FLOOR);
endmodule

// File: rtl/tc_float_normaliser.sv
module tc_float_normaliser
  import tcfn_pkg::*;
#(
  parameter int MANT_W     = 8,
  parameter int EXP_W      = 4,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [MANT_W-1:0] in_mant,
  input  logic [EXP_W-1:0]  in_exp,
  output logic              busy,
  output logic              out_valid,
  output logic [MANT_W-1:0] out_mant,
  output logic [EXP_W-1:0]  out_exp,
  output logic              out_uflow
);
  localparam logic [EXP_W-1:0] EXP_MIN = {1'b1, {(EXP_W-1){1'b0}}};

  logic rst_int_n;

  tcfn_state_e       state_q, state_n;
  logic [MANT_W-1:0] mant_q, mant_n;
  logic [EXP_W-1:0]  exp_q, exp_n;
  logic              done_q, done_n;
  logic              uflow_q, uflow_n;
  logic              dp_en;

  logic              in_zero, in_norm;
  logic [MANT_W-1:0] sh_mant;
  logic [EXP_W-1:0]  sh_exp;
  logic              sh_norm, at_floor;

  tcfn_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  tcfn_classify #(.MW(MANT_W)) u_cls (
    .mant    (in_mant),
    .is_zero (in_zero),
    .is_norm (in_norm)
  );

  tcfn_step #(.MW(MANT_W), .EW(EXP_W)) u_step (
    .mant     (mant_q),
    .expo     (exp_q),
    .mant_sh  (sh_mant),
    .expo_dec (sh_exp),
    .sh_norm  (sh_norm),
    .at_floor (at_floor)
  );

  // Next-state logic
  always_comb begin
    state_n = state_q;
    mant_n  = mant_q;
    exp_n   = exp_q;
    uflow_n = uflow_q;
    done_n  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          uflow_n = 1'b0;
          mant_n  = in_mant;
          exp_n   = in_exp;
          if (in_zero) begin
            exp_n  = EXP_MIN;
            done_n = 1'b1;
          end else if (in_norm) begin
            done_n = 1'b1;
          end else begin
            state_n = ST_SHIFT;
          end
        end
      end
      ST_SHIFT: begin
        if (at_floor) begin
          uflow_n = 1'b1;
          done_n  = 1'b1;
          state_n = ST_IDLE;
        end else begin
          mant_n = sh_mant;
          exp_n  = sh_exp;
          if (sh_norm) begin
            done_n  = 1'b1;
            state_n = ST_IDLE;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign dp_en = (state_q == ST_SHIFT) || in_valid;

  // Registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      mant_q  <= '0;
      exp_q   <= '0;
      uflow_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= done_n;
      if (dp_en) begin
        state_q <= state_n;
        mant_q  <= mant_n;
        exp_q   <= exp_n;
        uflow_q <= uflow_n;
      end
    end
  end

  assign busy      = (state_q == ST_SHIFT);
  assign out_valid = done_q;
  assign out_mant  = mant_q;
  assign out_exp   = exp_q;
  assign out_uflow = uflow_q;
endmodule

// File: rtl/tcfn_norm_chk.sv
module tcfn_norm_chk #(
  parameter int MW = 8,
  parameter int EW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          busy,
  input logic          out_valid,
  input logic [MW-1:0] out_mant,
  input logic [EW-1:0] out_exp,
  input logic          out_uflow
);
  localparam logic [EW-1:0] EXP_MIN = {1'b1, {(EW-1){1'b0}}};
  localparam logic [EW-1:0] EXP_ONE = {{(EW-1){1'b0}}, 1'b1};

  // R3
  step_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> (out_mant == {$past(out_mant[MW-2:0]), 1'b0}));

  // R3
  step_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> (out_exp == $past(out_exp) - EXP_ONE));

  // R4
  done_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_uflow) |->
      ((out_mant[MW-1] != out_mant[MW-2]) || (out_mant == '0 && out_exp == EXP_MIN)));

  // R4
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !busy);

  // R6
  uflow_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_uflow) |-> (out_exp == EXP_MIN));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !in_valid) |=> !out_valid);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(busy) && !$past(in_valid)) |-> ($stable(out_mant) && $stable(out_exp)));
endmodule

bind tc_float_normaliser tcfn_norm_chk #(.MW(MANT_W), .EW(EXP_W)) u_norm_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .busy      (busy),
  .out_valid (out_valid),
  .out_mant  (out_mant),
  .out_exp   (out_exp),
  .out_uflow (out_uflow)
);

// File: tb/tb_tc_float_normaliser.sv
module tb_tc_float_normaliser;
  localparam int CLK_P = 10;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_mant;
  logic [3:0] in_exp;
  logic       busy;
  logic       out_valid;
  logic [7:0] out_mant;
  logic [3:0] out_exp;
  logic       out_uflow;

  int checks = 0;
  int errors = 0;

  tc_float_normaliser dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_mant   (in_mant),
    .in_exp    (in_exp),
    .busy      (busy),
    .out_valid (out_valid),
    .out_mant  (out_mant),
    .out_exp   (out_exp),
    .out_uflow (out_uflow)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Offer one value, count edges until out_valid, then check the result.
  task automatic run_case(input logic [7:0] m, input logic [3:0] e,
                          input logic [7:0] em, input logic [3:0] ee,
                          input bit eu, input int edges, input string req,
                          input bit poke_busy);
    int cnt;
    @(negedge clk);
    in_valid = 1'b1; in_mant = m; in_exp = e;
    @(posedge clk);
    cnt = 1;
    @(negedge clk);
    in_valid = 1'b0;
    if (edges == 1) check(!busy, req, "busy after accept", busy, 0);
    while (!out_valid && cnt < 20) begin
      if (poke_busy && busy) begin
        in_valid = 1'b1; in_mant = 8'b0100_0000; in_exp = 4'b0000;
      end
      @(posedge clk);
      cnt++;
      @(negedge clk);
      in_valid = 1'b0;
    end
    check(cnt == edges, req, "edges to done", cnt, edges);
    check(out_mant == em, req, "mantissa", out_mant, em);
    check(out_exp == ee, req, "exponent", out_exp, ee);
    check(out_uflow == eu, req, "underflow", out_uflow, eu);
    @(negedge clk);
    check(!out_valid, "R8", "done pulse width", out_valid, 0);
    check(!busy, req, "busy after done", busy, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_mant = '0; in_exp = '0;
    repeat (3) @(negedge clk);
    check(!busy && !out_valid && !out_uflow, "R1", "flags in reset",
          {busy, out_valid, out_uflow}, 0);
    check(out_mant == 0 && out_exp == 0, "R1", "data in reset",
          {out_mant, out_exp}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!out_valid && !busy, "R1", "flags after release", {busy, out_valid}, 0);
  endtask

  task automatic t_back_to_back();
    // R8: a new input accepted on the done edge keeps out_valid high
    @(negedge clk);
    in_valid = 1'b1; in_mant = 8'b0110_0000; in_exp = 4'b0010;
    @(negedge clk);
    check(out_valid && out_mant == 8'b0110_0000, "R8", "first done", out_mant, 8'h60);
    in_mant = 8'b1001_0000; in_exp = 4'b0001;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_mant == 8'b1001_0000, "R8", "second done", out_mant, 8'h90);
    @(negedge clk);
    check(!out_valid, "R8", "done drops", out_valid, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    // R2: already normal, positive and negative
    run_case(8'b0101_0101, 4'b0011, 8'b0101_0101, 4'b0011, 1'b0, 1, "R2", 1'b0);
    run_case(8'b1011_0000, 4'b1110, 8'b1011_0000, 4'b1110, 1'b0, 1, "R2", 1'b0);
    // R9: 5.75 and a negative value
    run_case(8'b0001_0111, 4'b0101, 8'b0101_1100, 4'b0011, 1'b0, 3, "R9", 1'b0);
    run_case(8'b1111_0100, 4'b0000, 8'b1010_0000, 4'b1101, 1'b0, 4, "R9", 1'b0);
    // R4 and R3: longest runs
    run_case(8'b1111_1111, 4'b0111, 8'b1000_0000, 4'b0000, 1'b0, 8, "R4", 1'b0);
    run_case(8'b0000_0001, 4'b0111, 8'b0100_0000, 4'b0001, 1'b0, 7, "R3", 1'b0);
    // R5: zero mantissa
    run_case(8'b0000_0000, 4'b0101, 8'b0000_0000, 4'b1000, 1'b0, 1, "R5", 1'b0);
    // R6: underflow part way, at the first step, and finishing exactly at the floor
    run_case(8'b0000_0011, 4'b1010, 8'b0000_1100, 4'b1000, 1'b1, 4, "R6", 1'b0);
    run_case(8'b0000_0001, 4'b1000, 8'b0000_0001, 4'b1000, 1'b1, 2, "R6", 1'b0);
    // R8: underflow flag cleared by the next accepted input
    run_case(8'b0010_0000, 4'b1001, 8'b0100_0000, 4'b1000, 1'b0, 2, "R8", 1'b0);
    // R7: in_valid driven while busy
    run_case(8'b0000_0001, 4'b0111, 8'b0100_0000, 4'b0001, 1'b0, 7, "R7", 1'b1);
    t_back_to_back();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule